// File: doc/BRIEF.md
# Gated Burst PRBS Bit-Error Checker

This block receives a serial data stream, one bit per clock qualified by a valid strobe, and compares it against a pseudo-random binary sequence produced on chip. It tallies how many bits it compared and how many of those were wrong. No seed is supplied from outside. The checker loads its sequence generator from the received bits, confirms the prediction over a run of clean bits, and then waits out a fixed settling window before any bit enters the tallies.

A gate input removes stretches of the stream from checking. Each ignored stretch is rounded up to a whole number of 512-bit blocks. In burst mode, each end of a gated stretch opens a new burst. The checker then discards its lock and re-acquires the sequence from that burst's own data. This suits bursty links such as recirculation loops, where the data between bursts is unrelated.

A sticky flag reports gate timing that breaks the burst rules: pulses that are too short, bursts that are too short, and too little trailing data after a burst closes. A clear input zeroes both tallies and the flag.

Top module: `prbs_burst_checker`

## Requirements
- R1: When the checker is locked and its settling window has expired, every valid, ungated bit increments `bit_count`. A bit that differs from the predicted sequence bit also increments `err_count`.
- R2: A valid bit is ignored while the registered gate is high. After the gate falls, bits stay ignored until the number of ignored valid bits is a whole multiple of 512. Ignored bits never change either tally.
- R3: After a restart event, the first 1536 valid ungated bits are never counted. Restart events are release of reset, a change of `poly_sel`, the start of a burst in burst mode, and a loss of lock.
- R4: Acquisition loads the generator with the first N received bits, where N is the polynomial order. It then requires 32 consecutive matching predictions before `in_sync` rises. Any mismatch before the settling window expires returns the checker to loading. A burst start clears `in_sync`.
- R5: Compared bits are grouped into windows of 256. When a window accumulates more than 16 errors, lock is dropped at that bit and R3's window restarts. The bit that triggers the drop is still counted.
- R6: Both tallies saturate at their all-ones value instead of wrapping. `clear_cnt` sets both tallies to zero and clears `gate_violation`.
- R7: `gate_violation` is set, and stays set until cleared, when the registered gate changes level after holding the previous level for fewer than 256 clock cycles. The first gate edge after reset is exempt.
- R8: In burst mode, `gate_violation` is set when the gate rises after fewer than 2560 valid bits arrived while it was low.
- R9: In burst mode, `gate_violation` is set when the gate falls after fewer than 1536 valid bits arrived while it was high.
- R10: `poly_sel` = 2'b00 selects x^7+x^6+1, 2'b01 selects x^15+x^14+1, and 2'b10 or 2'b11 selects x^31+x^28+1. The sequence recurrence is b[t] = b[t-order] XOR b[t-tap].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Received serial data bit |
| gate_in | input | 1 | High suppresses checking; sampled synchronously |
| burst_mode | input | 1 | Enables per-burst resynchronization and the burst timing rules |
| poly_sel | input | 2 | Sequence polynomial select |
| clear_cnt | input | 1 | Zeroes both tallies and the violation flag |
| bit_count | output | CNT_W | Saturating count of compared bits |
| err_count | output | CNT_W | Saturating count of mismatched bits |
| in_sync | output | 1 | Generator is locked to the stream |
| gate_violation | output | 1 | Sticky gate-protocol violation flag |

## Verification
The hardest situation to reach is the lock drop caused by error density. The bench must be locked, past the settling window, and positioned exactly on a 256-bit density-window boundary when the errors begin. Otherwise the number of errors tallied before the drop depends on where the window lines up.

The stimulus gets there by first changing the polynomial, which restarts acquisition from a known point. It then sends exactly 1536 + 512 clean bits, followed by data with every third bit inverted. The drop therefore lands on the 49th bit, with exactly 17 errors tallied.

A second hard corner is the rounding of the gated region. The bench corrupts the 212 bits that follow the gate's fall. Those bits are tallied only if the 512-bit rounding fails.

// File: rtl/gbc_pkg.sv
package gbc_pkg;

    typedef enum logic [1:0] {
        SY_SEED   = 2'd0,
        SY_VERIFY = 2'd1,
        SY_LOCK   = 2'd2
    } sync_st_e;

    localparam int LFSR_W = 31;

    function automatic logic [5:0] poly_order(input logic [1:0] sel);
        case (sel)
            2'b00:   poly_order = 6'd7;
            2'b01:   poly_order = 6'd15;
            default: poly_order = 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/gbc_prbs_tap.sv
module gbc_prbs_tap
    import gbc_pkg::*;
(
    input  logic [LFSR_W-1:0] state,
    input  logic [1:0]        sel,
    output logic              pred
);
    logic [2:0] cand;

    for (genvar g = 0; g < 3; g++) begin : g_poly
        localparam int HI = (g == 0) ? 7 : (g == 1) ? 15 : 31;
        localparam int LO = (g == 0) ? 6 : (g == 1) ? 14 : 28;
        localparam logic [LFSR_W-1:0] MASK =
            (LFSR_W'(1) << (HI - 1)) | (LFSR_W'(1) << (LO - 1));
        assign cand[g] = ^(state & MASK);
    end

    always_comb begin
        case (sel)
            2'b00:   pred = cand[0];
            2'b01:   pred = cand[1];
            default: pred = cand[2];
        endcase
    end

endmodule

// File: rtl/gbc_gate_ctrl.sv
module gbc_gate_ctrl #(
    parameter int BLOCK_BITS    = 512,
    parameter int PASSIVE_BITS  = 2560,
    parameter int BACKLASH_BITS = 1536,
    parameter int MIN_PULSE     = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic bit_valid,
    input  logic burst_mode,
    input  logic clear,
    output logic blocked,
    output logic burst_start,
    output logic violation
);
    localparam int IGN_W   = $clog2(BLOCK_BITS);
    localparam int LVL_MAX = (PASSIVE_BITS > BACKLASH_BITS) ? PASSIVE_BITS : BACKLASH_BITS;
    localparam int LVL_W   = $clog2(LVL_MAX + 1);
    localparam int PW_W    = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic             gate;
        logic             gate_p;
        logic             blk_p;
        logic             seen;
        logic [IGN_W-1:0] ign;
        logic [LVL_W-1:0] lvl;
        logic [PW_W-1:0]  pw;
        logic             viol;
    } gate_st_t;

    gate_st_t gs_d, gs_q;
    logic     edge_seen;

    always_comb begin
        gs_d        = gs_q;
        gs_d.gate   = gate_in;
        gs_d.gate_p = gs_q.gate;
        blocked     = gs_q.gate | (gs_q.ign != '0);
        gs_d.blk_p  = blocked;
        burst_start = burst_mode & gs_q.blk_p & ~blocked;
        edge_seen   = gs_q.gate ^ gs_q.gate_p;

        if (bit_valid && blocked) begin
            gs_d.ign = (gs_q.ign == IGN_W'(BLOCK_BITS - 1)) ? '0 : gs_q.ign + 1'b1;
        end

        if (edge_seen) begin
            gs_d.seen = 1'b1;
            gs_d.pw   = PW_W'(1);
            gs_d.lvl  = bit_valid ? LVL_W'(1) : '0;
            if (gs_q.seen && (gs_q.pw < PW_W'(MIN_PULSE))) begin
                gs_d.viol = 1'b1;
            end
            if (burst_mode) begin
                if (gs_q.gate && (gs_q.lvl < LVL_W'(PASSIVE_BITS))) begin
                    gs_d.viol = 1'b1;
                end
                if (!gs_q.gate && (gs_q.lvl < LVL_W'(BACKLASH_BITS))) begin
                    gs_d.viol = 1'b1;
                end
            end
        end else begin
            if (gs_q.pw != PW_W'(MIN_PULSE)) begin
                gs_d.pw = gs_q.pw + 1'b1;
            end
            if (bit_valid && (gs_q.lvl != LVL_W'(LVL_MAX))) begin
                gs_d.lvl = gs_q.lvl + 1'b1;
            end
        end

        if (clear) begin
            gs_d.viol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q <= '0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign violation = gs_q.viol;

    // R7: the flag holds until a clear
    p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !clear) |=> violation);

    // R7: a short level followed by an edge raises the flag
    p_short_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && gs_q.seen && (gs_q.pw < PW_W'(MIN_PULSE)) && !clear) |=> violation);

endmodule

// File: rtl/gbc_sync_core.sv
module gbc_sync_core
    import gbc_pkg::*;
#(
    parameter int SYNC_BITS   = 1536,
    parameter int VERIFY_BITS = 32,
    parameter int DENS_WIN    = 256,
    parameter int DENS_MAX    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       blocked,
    input  logic       burst_start,
    input  logic [1:0] poly_sel,
    output logic       cmp_en,
    output logic       cmp_err,
    output logic       in_sync
);
    localparam int WW  = $clog2(SYNC_BITS + 1);
    localparam int VW  = $clog2(VERIFY_BITS + 1);
    localparam int DBW = $clog2(DENS_WIN + 1);
    localparam int DEW = $clog2(DENS_MAX + 2);

    typedef struct packed {
        sync_st_e          st;
        logic [LFSR_W-1:0] lfsr;
        logic [1:0]        poly;
        logic [4:0]        seed;
        logic [VW-1:0]     ver;
        logic [WW-1:0]     win;
        logic [DBW-1:0]    dbits;
        logic [DEW-1:0]    derr;
    } sync_t;

    sync_t      sc_d, sc_q;
    logic       pred;
    logic       restart;
    logic       active;
    logic       mism;
    logic       win_done;
    logic [5:0] ord;
    logic [DBW-1:0] nb;
    logic [DEW-1:0] ne;

    gbc_prbs_tap i_tap (
        .state (sc_q.lfsr),
        .sel   (poly_sel),
        .pred  (pred)
    );

    always_comb begin
        sc_d     = sc_q;
        cmp_en   = 1'b0;
        cmp_err  = 1'b0;
        win_done = 1'b0;
        nb       = '0;
        ne       = '0;
        ord      = poly_order(poly_sel);
        sc_d.poly = poly_sel;
        restart  = burst_start | (poly_sel != sc_q.poly);
        active   = bit_valid & ~blocked;
        mism     = bit_in ^ pred;

        if (restart) begin
            sc_d.st    = SY_SEED;
            sc_d.seed  = '0;
            sc_d.ver   = '0;
            sc_d.win   = '0;
            sc_d.dbits = '0;
            sc_d.derr  = '0;
        end

        if (bit_valid) begin
            win_done = (sc_d.win == WW'(SYNC_BITS));
            if (active && !win_done) begin
                sc_d.win = sc_d.win + 1'b1;
            end
            case (sc_d.st)
                SY_SEED: begin
                    if (active) begin
                        sc_d.lfsr = {sc_q.lfsr[LFSR_W-2:0], bit_in};
                        if (({1'b0, sc_d.seed} + 6'd1) == ord) begin
                            sc_d.st   = SY_VERIFY;
                            sc_d.seed = '0;
                            sc_d.ver  = '0;
                        end else begin
                            sc_d.seed = sc_d.seed + 1'b1;
                        end
                    end
                end
                SY_VERIFY: begin
                    sc_d.lfsr = {sc_q.lfsr[LFSR_W-2:0], pred};
                    if (active) begin
                        if (mism) begin
                            sc_d.st   = SY_SEED;
                            sc_d.seed = '0;
                            sc_d.ver  = '0;
                        end else if (sc_d.ver == VW'(VERIFY_BITS - 1)) begin
                            sc_d.st = SY_LOCK;
                        end else begin
                            sc_d.ver = sc_d.ver + 1'b1;
                        end
                    end
                end
                SY_LOCK: begin
                    sc_d.lfsr = {sc_q.lfsr[LFSR_W-2:0], pred};
                    if (active) begin
                        if (!win_done) begin
                            if (mism) begin
                                sc_d.st   = SY_SEED;
                                sc_d.seed = '0;
                                sc_d.ver  = '0;
                            end
                        end else begin
                            cmp_en  = 1'b1;
                            cmp_err = mism;
                            nb = sc_d.dbits + 1'b1;
                            ne = sc_d.derr + DEW'(mism);
                            if (ne > DEW'(DENS_MAX)) begin
                                sc_d.st    = SY_SEED;
                                sc_d.seed  = '0;
                                sc_d.ver   = '0;
                                sc_d.win   = '0;
                                sc_d.dbits = '0;
                                sc_d.derr  = '0;
                            end else if (nb == DBW'(DENS_WIN)) begin
                                sc_d.dbits = '0;
                                sc_d.derr  = '0;
                            end else begin
                                sc_d.dbits = nb;
                                sc_d.derr  = ne;
                            end
                        end
                    end
                end
                default: begin
                    sc_d.st = SY_SEED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q      <= '0;
            sc_q.st   <= SY_SEED;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign in_sync = (sc_q.st == SY_LOCK);

    // R4: lock is only reached from the verify phase
    p_lock_via_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(sc_q.st == SY_VERIFY));

    // R3: a restart event leaves the checker unlocked with a fresh window
    p_restart_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!in_sync && (sc_q.win <= WW'(1))));

    // R5: the density tally never holds more than the allowed errors
    p_dens_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q.derr <= DEW'(DENS_MAX));

endmodule

// File: rtl/gbc_sat_cnt.sv
module gbc_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // R6: a full tally never wraps
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '1) && !clear) |=> (count == '1));

    // R6: clear empties the tally
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/prbs_burst_checker.sv
module prbs_burst_checker #(
    parameter int CNT_W         = 32,
    parameter int BLOCK_BITS    = 512,
    parameter int SYNC_BITS     = 1536,
    parameter int BACKLASH_BITS = 1536,
    parameter int PASSIVE_BITS  = 2560,
    parameter int MIN_PULSE     = 256,
    parameter int VERIFY_BITS   = 32,
    parameter int DENS_WIN      = 256,
    parameter int DENS_MAX      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             gate_in,
    input  logic             burst_mode,
    input  logic [1:0]       poly_sel,
    input  logic             clear_cnt,
    output logic [CNT_W-1:0] bit_count,
    output logic [CNT_W-1:0] err_count,
    output logic             in_sync,
    output logic             gate_violation
);
    logic blocked;
    logic burst_start;
    logic cmp_en;
    logic cmp_err;

    gbc_gate_ctrl #(
        .BLOCK_BITS    (BLOCK_BITS),
        .PASSIVE_BITS  (PASSIVE_BITS),
        .BACKLASH_BITS (BACKLASH_BITS),
        .MIN_PULSE     (MIN_PULSE)
    ) i_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_in     (gate_in),
        .bit_valid   (bit_valid),
        .burst_mode  (burst_mode),
        .clear       (clear_cnt),
        .blocked     (blocked),
        .burst_start (burst_start),
        .violation   (gate_violation)
    );

    gbc_sync_core #(
        .SYNC_BITS   (SYNC_BITS),
        .VERIFY_BITS (VERIFY_BITS),
        .DENS_WIN    (DENS_WIN),
        .DENS_MAX    (DENS_MAX)
    ) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .blocked     (blocked),
        .burst_start (burst_start),
        .poly_sel    (poly_sel),
        .cmp_en      (cmp_en),
        .cmp_err     (cmp_err),
        .in_sync     (in_sync)
    );

    gbc_sat_cnt #(.W(CNT_W)) i_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_cnt),
        .inc   (cmp_en),
        .count (bit_count)
    );

    gbc_sat_cnt #(.W(CNT_W)) i_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_cnt),
        .inc   (cmp_en & cmp_err),
        .count (err_count)
    );

    // R2: a gated bit leaves the bit tally untouched
    p_blocked_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !clear_cnt) |=> $stable(bit_count));

    // R4: a burst start always clears lock
    p_burst_desync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !in_sync);

    // R1: errors never outnumber compared bits
    p_err_le_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= bit_count);

endmodule

// File: tb/test_prbs_burst_checker.sv
module test_prbs_burst_checker;
    localparam int CW   = 11;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          gate_in = 1'b0;
    logic          burst_mode = 1'b0;
    logic [1:0]    poly_sel = 2'b00;
    logic          clear_cnt = 1'b0;
    logic [CW-1:0] bit_count;
    logic [CW-1:0] err_count;
    logic          in_sync;
    logic          gate_violation;

    int total = 0;
    int bad   = 0;
    int exp_bits = 0;
    int exp_errs = 0;

    logic [30:0] gs;
    int gord = 7;
    int gtap = 6;

    always #4 clk = ~clk;

    prbs_burst_checker #(.CNT_W(CW)) i_prbs_burst_checker (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_valid      (bit_valid),
        .bit_in         (bit_in),
        .gate_in        (gate_in),
        .burst_mode     (burst_mode),
        .poly_sel       (poly_sel),
        .clear_cnt      (clear_cnt),
        .bit_count      (bit_count),
        .err_count      (err_count),
        .in_sync        (in_sync),
        .gate_violation (gate_violation)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_exp(input int nb, input int ne);
        exp_bits = (exp_bits + nb > CMAX) ? CMAX : exp_bits + nb;
        exp_errs = (exp_errs + ne > CMAX) ? CMAX : exp_errs + ne;
    endtask

    task automatic reseed(input logic [1:0] sel);
        case (sel)
            2'b00:   begin gord = 7;  gtap = 6;  end
            2'b01:   begin gord = 15; gtap = 14; end
            default: begin gord = 31; gtap = 28; end
        endcase
        gs = 31'h1234_5678 | 31'h1;
    endtask

    task automatic send(input int n, input int fmod, input int foff);
        for (int i = 0; i < n; i++) begin
            logic nb;
            @(negedge clk);
            nb = gs[gord-1] ^ gs[gtap-1];
            gs = {gs[29:0], nb};
            if (fmod != 0 && (i % fmod) == foff) nb = ~nb;
            bit_valid = 1'b1;
            bit_in    = nb;
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk);
        bit_valid = 1'b0;
        gate_in   = v;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_cnt = 1'b1;
        @(negedge clk);
        clear_cnt = 1'b0;
        exp_bits = 0;
        exp_errs = 0;
    endtask

    task automatic check_counts(input string req);
        chk(req, "bit_count", int'(bit_count), exp_bits);
        chk(req, "err_count", int'(err_count), exp_errs);
    endtask

    task automatic t_reset();
        chk("R6", "reset bit_count", int'(bit_count), 0);
        chk("R6", "reset err_count", int'(err_count), 0);
        chk("R4", "reset in_sync", int'(in_sync), 0);
        chk("R7", "reset violation", int'(gate_violation), 0);
    endtask

    task automatic t_clean_prbs7();
        reseed(2'b00);
        send(2000, 0, 0);
        add_exp(2000 - 1536, 0);
        check_counts("R3");
        chk("R4", "in_sync after clean", int'(in_sync), 1);
        chk("R10", "prbs7 errors", int'(err_count), 0);
    endtask

    task automatic t_injected();
        send(300, 60, 30);
        add_exp(300, 5);
        check_counts("R1");
        chk("R1", "in_sync kept", int'(in_sync), 1);
    endtask

    task automatic t_gate_round();
        set_gate(1'b1);
        send(300, 1, 0);
        set_gate(1'b0);
        send(212, 1, 0);
        send(500, 0, 0);
        add_exp(500, 0);
        check_counts("R2");
        chk("R7", "long gate no flag", int'(gate_violation), 0);
    endtask

    task automatic t_density();
        idle(1);
        poly_sel = 2'b01;
        reseed(2'b01);
        send(2048, 0, 0);
        add_exp(512, 0);
        check_counts("R10");
        send(100, 3, 0);
        add_exp(49, 17);
        check_counts("R5");
        chk("R5", "in_sync dropped", int'(in_sync), 0);
        send(2000, 0, 0);
        add_exp(515, 0);
        check_counts("R6");
        chk("R5", "in_sync regained", int'(in_sync), 1);
    endtask

    task automatic t_short_pulse();
        set_gate(1'b1);
        idle(100);
        set_gate(1'b0);
        idle(4);
        chk("R7", "short pulse flag", int'(gate_violation), 1);
        check_counts("R2");
        do_clear();
        check_counts("R6");
        chk("R6", "clear flag", int'(gate_violation), 0);
    endtask

    task automatic t_prbs31_sat();
        idle(1);
        poly_sel = 2'b10;
        reseed(2'b10);
        send(4000, 0, 0);
        add_exp(4000 - 1536, 0);
        chk("R6", "saturated bit_count", int'(bit_count), CMAX);
        chk("R10", "prbs31 errors", int'(err_count), exp_errs);
        do_clear();
    endtask

    task automatic t_burst();
        burst_mode = 1'b1;
        set_gate(1'b1);
        poly_sel = 2'b01;
        send(1600, 1, 0);
        set_gate(1'b0);
        send(448, 1, 0);
        reseed(2'b01);
        send(10, 0, 0);
        chk("R4", "in_sync cleared at burst", int'(in_sync), 0);
        send(2990, 0, 0);
        add_exp(3000 - 1536, 0);
        check_counts("R3");
        chk("R4", "burst locked", int'(in_sync), 1);
        chk("R8", "legal burst no flag", int'(gate_violation), 0);
    endtask

    task automatic t_short_passive();
        set_gate(1'b1);
        send(1600, 1, 0);
        set_gate(1'b0);
        send(448, 1, 0);
        reseed(2'b01);
        send(1000, 0, 0);
        set_gate(1'b1);
        idle(3);
        chk("R8", "short burst flag", int'(gate_violation), 1);
        do_clear();
    endtask

    task automatic t_short_backlash();
        send(600, 1, 0);
        set_gate(1'b0);
        idle(3);
        chk("R9", "short backlash flag", int'(gate_violation), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        reseed(2'b00);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_clean_prbs7();
        t_injected();
        t_gate_round();
        t_density();
        t_short_pulse();
        t_prbs31_sat();
        t_burst();
        t_short_passive();
        t_short_backlash();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule